// File: doc/BRIEF.md
# Single-Precision Newton Correction Step

This block produces the correction factor used by one Newton-Raphson refinement pass on a reciprocal or a reciprocal square root. It takes two IEEE-754 single-precision operands, usually the value being inverted and the current estimate or its square. It forms their product, subtracts it from a fixed constant and, in square-root mode, halves the difference. The caller multiplies its estimate by the returned factor to refine it. Producing the estimate and running the iteration loop are left to the surrounding datapath.

One operation may be issued per clock. The result appears one cycle after `in_valid`, registered together with `out_valid`, and holds its value while no operation is issued. Rounding is always to nearest-even. Subnormal values are flushed to zero, both on the operands and on the rounded intermediate and final results. The pairing of an infinity with a zero is defined so that it gives a usable factor instead of a NaN.

Top module: `nstep_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises with `in_valid` low, `out_valid` is 0 and `result` is 0x00000000.
- R2: `out_valid` equals `in_valid` of the previous cycle. When `in_valid` was low, `result` keeps the value it had before, whatever the operands and mode were.
- R3: With `mode` = 0 (reciprocal step), `result` is 2.0 minus op_a×op_b. The product is first rounded to single precision (nearest-even) and the difference is then rounded again.
- R4: With `mode` = 1 (square-root step), `result` is (3.0 minus the rounded product) divided by two. The halving only lowers the exponent field (bits 30:23) by one and adds no further rounding.
- R5: If one operand is ±infinity (exponent field all ones, fraction 0) and the other is ±zero, in either order and with any signs, the product is taken as zero. `result` is then exactly 0x40000000 for mode 0 and exactly 0x3FC00000 for mode 1.
- R6: If either operand is a NaN (exponent field all ones, fraction nonzero), `result` is the quiet NaN 0x7FC00000. This also holds when the other operand is zero or infinite.
- R7: An infinite product gives an infinite `result` of the opposite sign in both modes: 0xFF800000 for a positive product and 0x7F800000 for a negative one. The product is infinite when an infinity meets a finite nonzero operand, or when the rounded product overflows.
- R8: An operand with exponent field 0 is treated as zero, and a rounded product below the smallest normal magnitude is flushed to zero. Either way the result is the R5 constant for the mode. `result` never carries a zero exponent field with a nonzero fraction.
- R9: When the product equals the mode constant exactly, `result` is +0 (0x00000000) in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| mode | input | 1 | 0 = reciprocal step, 1 = square-root step |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| out_valid | output | 1 | `result` belongs to the operation issued in the previous cycle |
| result | output | 32 | Single-precision correction factor |

## Verification
The bench builds the unit with its default 8-bit exponent and 23-bit fraction. Under that format, the product of two operands fits exactly in a double-precision real. The difference from 2.0 or 3.0 is also exact there, provided the product's magnitude stays within about 2^±20, so the reference model needs only a single explicit nearest-even rounding per stage. That is why the random operands are kept in that band and often paired as near-reciprocals, which drives deep cancellation in the subtraction. Directed cases cover infinity-zero pairs, NaNs, overflow, flush-to-zero and exact cancellation.

// File: rtl/nstep_pkg.sv
package nstep_pkg;

    // Operand / product classification flags
    typedef struct packed {
        logic is_zero;
        logic is_inf;
        logic is_nan;
    } nstep_cls_t;

    // Step kind selected by the mode pin
    typedef enum logic {
        NSTEP_RECIP = 1'b0,
        NSTEP_RSQRT = 1'b1
    } nstep_mode_e;

endpackage

// File: rtl/nstep_classify.sv
module nstep_classify
    import nstep_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] op_i,
    output nstep_cls_t   cls_o
);

    logic exp_ones;
    logic exp_zero;
    logic man_zero;

    always_comb begin
        exp_ones      = &op_i[W-2:MAN_W];
        exp_zero      = ~|op_i[W-2:MAN_W];
        man_zero      = ~|op_i[MAN_W-1:0];
        // exponent field 0 covers true zero and flushed subnormals
        cls_o.is_zero = exp_zero;
        cls_o.is_inf  = exp_ones & man_zero;
        cls_o.is_nan  = exp_ones & ~man_zero;
    end

endmodule

// File: rtl/nstep_mul.sv
module nstep_mul
    import nstep_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  nstep_cls_t   a_cls_i,
    input  nstep_cls_t   b_cls_i,
    output logic [W-1:0] prod_o,
    output nstep_cls_t   prod_cls_o
);

    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EV_W   = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam logic signed [EV_W-1:0] BIAS_E = EV_W'(BIAS);
    localparam logic signed [EV_W-1:0] EMAX_E = EV_W'(EMAX);
    localparam logic signed [EV_W-1:0] ONE_E  = EV_W'(1);
    localparam logic signed [EV_W-1:0] ZERO_E = '0;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic                   sgn;
    logic [PROD_W-1:0]      full;
    logic signed [EV_W-1:0] e_sum;
    logic signed [EV_W-1:0] e_norm;
    logic signed [EV_W-1:0] e_fin;
    logic [MAN_W-1:0]       man_t;
    logic                   guard;
    logic                   sticky;
    logic                   rnd;
    logic [MAN_W:0]         man_r;
    logic                   ovf;
    logic                   unf;
    logic                   inf_zero;

    always_comb begin
        sgn   = a_i[W-1] ^ b_i[W-1];
        full  = PROD_W'({1'b1, a_i[MAN_W-1:0]}) * PROD_W'({1'b1, b_i[MAN_W-1:0]});
        e_sum = $signed({2'b00, a_i[W-2:MAN_W]}) + $signed({2'b00, b_i[W-2:MAN_W]}) - BIAS_E;

        // normalise the [1,4) significand product to [1,2)
        if (full[PROD_W-1]) begin
            man_t  = full[PROD_W-2 -: MAN_W];
            guard  = full[PROD_W-2-MAN_W];
            sticky = |full[PROD_W-3-MAN_W:0];
            e_norm = e_sum + ONE_E;
        end else begin
            man_t  = full[PROD_W-3 -: MAN_W];
            guard  = full[PROD_W-3-MAN_W];
            sticky = |full[PROD_W-4-MAN_W:0];
            e_norm = e_sum;
        end

        // round to nearest, ties to even
        rnd   = guard & (sticky | man_t[0]);
        man_r = {1'b0, man_t} + (MAN_W+1)'(rnd);
        e_fin = man_r[MAN_W] ? e_norm + ONE_E : e_norm;
        ovf   = e_fin >= EMAX_E;
        unf   = e_fin <= ZERO_E;

        inf_zero = (a_cls_i.is_inf & b_cls_i.is_zero) | (a_cls_i.is_zero & b_cls_i.is_inf);

        prod_cls_o = '0;
        if (a_cls_i.is_nan | b_cls_i.is_nan) begin
            prod_o            = QNAN;
            prod_cls_o.is_nan = 1'b1;
        end else if (inf_zero) begin
            // forced zero product instead of the invalid case
            prod_o             = '0;
            prod_cls_o.is_zero = 1'b1;
        end else if (a_cls_i.is_inf | b_cls_i.is_inf | ovf) begin
            prod_o            = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            prod_cls_o.is_inf = 1'b1;
        end else if (a_cls_i.is_zero | b_cls_i.is_zero | unf) begin
            prod_o             = {sgn, {(W-1){1'b0}}};
            prod_cls_o.is_zero = 1'b1;
        end else begin
            prod_o = {sgn, e_fin[EXP_W-1:0], man_r[MAN_W-1:0]};
        end
    end

endmodule

// File: rtl/nstep_addc.sv
module nstep_addc
    import nstep_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0] p_i,
    input  nstep_cls_t   p_cls_i,
    input  logic         rsqrt_i,
    output logic [W-1:0] res_o
);

    localparam int GW    = MAN_W + 4;          // hidden + fraction + guard/round/sticky
    localparam int LZ_W  = $clog2(GW) + 1;
    localparam int EV_W  = EXP_W + 2;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX  = (1 << EXP_W) - 1;
    localparam logic [EXP_W-1:0] CONST_EXP = EXP_W'(BIAS + 1);
    localparam logic signed [EV_W-1:0] EMAX_E = EV_W'(EMAX);
    localparam logic signed [EV_W-1:0] ONE_E  = EV_W'(1);
    localparam logic signed [EV_W-1:0] ZERO_E = '0;
    localparam logic [W-1:0] QNAN      = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0] TWO_BITS  = {1'b0, CONST_EXP, {MAN_W{1'b0}}};
    localparam logic [W-1:0] HALF3_BITS = {1'b0, EXP_W'(BIAS), 1'b1, {(MAN_W-1){1'b0}}};

    logic [MAN_W-1:0]       c_man;
    logic                   y_sgn;
    logic                   y_big;
    logic                   big_sgn;
    logic                   sml_sgn;
    logic [EXP_W-1:0]       big_e;
    logic [EXP_W-1:0]       sml_e;
    logic [MAN_W-1:0]       big_man;
    logic [MAN_W-1:0]       sml_man;
    logic [EXP_W-1:0]       diff;
    logic [GW-1:0]          big_m;
    logic [GW-1:0]          sml_full;
    logic [GW-1:0]          sml_al;
    logic                   sticky;
    logic                   eff_sub;
    logic [GW:0]            sum;
    logic [LZ_W-1:0]        lz;
    logic                   seen;
    logic [GW-1:0]          norm;
    logic signed [EV_W-1:0] e_big;
    logic signed [EV_W-1:0] e_n;
    logic signed [EV_W-1:0] e_r;
    logic signed [EV_W-1:0] e_h;
    logic                   rnd;
    logic [MAN_W:0]         man_r;
    logic                   canc;

    always_comb begin
        // constant operand: 2.0 or 3.0, always positive; product enters negated
        c_man = rsqrt_i ? {1'b1, {(MAN_W-1){1'b0}}} : '0;
        y_sgn = ~p_i[W-1];
        y_big = {p_i[W-2:MAN_W], p_i[MAN_W-1:0]} > {CONST_EXP, c_man};

        if (y_big) begin
            big_sgn = y_sgn;   big_e = p_i[W-2:MAN_W]; big_man = p_i[MAN_W-1:0];
            sml_sgn = 1'b0;    sml_e = CONST_EXP;      sml_man = c_man;
        end else begin
            big_sgn = 1'b0;    big_e = CONST_EXP;      big_man = c_man;
            sml_sgn = y_sgn;   sml_e = p_i[W-2:MAN_W]; sml_man = p_i[MAN_W-1:0];
        end

        // align the smaller operand, folding shifted-out bits into sticky
        diff     = big_e - sml_e;
        big_m    = {1'b1, big_man, 3'b000};
        sml_full = {1'b1, sml_man, 3'b000};
        sticky   = |(sml_full & ~({GW{1'b1}} << diff));
        sml_al   = (sml_full >> diff) | GW'(sticky);

        eff_sub = big_sgn ^ sml_sgn;
        sum     = eff_sub ? ({1'b0, big_m} - {1'b0, sml_al}) : ({1'b0, big_m} + {1'b0, sml_al});
        canc    = eff_sub && (sum == '0);

        lz   = '0;
        seen = 1'b0;
        for (int i = GW - 1; i >= 0; i--) begin
            if (!seen) begin
                if (sum[i]) seen = 1'b1;
                else        lz   = lz + LZ_W'(1);
            end
        end

        e_big = $signed({2'b00, big_e});
        if (!eff_sub && sum[GW]) begin
            norm = {sum[GW:2], sum[1] | sum[0]};
            e_n  = e_big + ONE_E;
        end else if (eff_sub) begin
            norm = sum[GW-1:0] << lz;
            e_n  = e_big - $signed({{(EV_W-LZ_W){1'b0}}, lz});
        end else begin
            norm = sum[GW-1:0];
            e_n  = e_big;
        end

        // round to nearest, ties to even
        rnd   = norm[2] & (norm[1] | norm[0] | norm[3]);
        man_r = {1'b0, norm[GW-2:3]} + (MAN_W+1)'(rnd);
        e_r   = man_r[MAN_W] ? e_n + ONE_E : e_n;
        // halving in square-root mode is an exponent decrement
        e_h   = rsqrt_i ? e_r - ONE_E : e_r;

        if (p_cls_i.is_nan) begin
            res_o = QNAN;
        end else if (p_cls_i.is_inf) begin
            res_o = {y_sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (p_cls_i.is_zero) begin
            res_o = rsqrt_i ? HALF3_BITS : TWO_BITS;
        end else if (canc) begin
            res_o = '0;
        end else if (e_r >= EMAX_E) begin
            res_o = {big_sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (e_h <= ZERO_E) begin
            res_o = {big_sgn, {(W-1){1'b0}}};
        end else begin
            res_o = {big_sgn, e_h[EXP_W-1:0], man_r[MAN_W-1:0]};
        end
    end

endmodule

// File: rtl/nstep_unit.sv
module nstep_unit
    import nstep_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         out_valid,
    output logic [W-1:0] result
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [W-1:0] QNAN_C  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0] TWO_C   = {1'b0, EXP_W'(BIAS + 1), {MAN_W{1'b0}}};
    localparam logic [W-1:0] HALF3_C = {1'b0, EXP_W'(BIAS), 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } nstep_state_t;

    logic [W-1:0] ops [2];
    nstep_cls_t   cls_v [2];
    logic [W-1:0] prod;
    nstep_cls_t   prod_cls;
    logic         rsqrt;
    logic [W-1:0] step_res;
    nstep_state_t st_d;
    nstep_state_t st_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign rsqrt  = (nstep_mode_e'(mode) == NSTEP_RSQRT);

    for (genvar g = 0; g < 2; g++) begin : g_cls
        nstep_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .op_i  (ops[g]),
            .cls_o (cls_v[g])
        );
    end

    nstep_mul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mul (
        .a_i        (op_a),
        .b_i        (op_b),
        .a_cls_i    (cls_v[0]),
        .b_cls_i    (cls_v[1]),
        .prod_o     (prod),
        .prod_cls_o (prod_cls)
    );

    nstep_addc #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_addc (
        .p_i     (prod),
        .p_cls_i (prod_cls),
        .rsqrt_i (rsqrt),
        .res_o   (step_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = step_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                              // R2
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                            // R2
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));                                       // R2
    AST_INFZERO_RCP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rsqrt && !cls_v[0].is_nan && !cls_v[1].is_nan &&
         ((cls_v[0].is_inf && cls_v[1].is_zero) || (cls_v[0].is_zero && cls_v[1].is_inf)))
        |=> result == TWO_C);                                                 // R5
    AST_INFZERO_RSQ: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsqrt && !cls_v[0].is_nan && !cls_v[1].is_nan &&
         ((cls_v[0].is_inf && cls_v[1].is_zero) || (cls_v[0].is_zero && cls_v[1].is_inf)))
        |=> result == HALF3_C);                                               // R5
    AST_NAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (cls_v[0].is_nan || cls_v[1].is_nan)) |=> result == QNAN_C); // R6
    AST_NO_SUBNORM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result[W-2:MAN_W] != '0 || result[MAN_W-1:0] == '0));   // R8

endmodule

// File: tb/nstep_unit_bench.sv
module nstep_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] H3   = 32'h3FC0_0000;

    nstep_unit u_nstep_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result)
    );

    always #4 clk = ~clk;

    function automatic real f2r(input logic [31:0] f);
        logic [63:0] d;
        int e;
        if (f[30:23] == 8'd0) return 0.0;
        e = int'(f[30:23]) - 127 + 1023;
        d = {f[31], 11'(e), f[22:0], 29'd0};
        return $bitstoreal(d);
    endfunction

    function automatic logic [31:0] r2f(input real v);
        logic [63:0] d;
        logic [23:0] mr;
        logic        inc;
        int          fe;
        if (v == 0.0) return 32'h0;
        d   = $realtobits(v);
        fe  = int'(d[62:52]) - 1023 + 127;
        inc = d[28] & ((|d[27:0]) | d[29]);
        mr  = {1'b0, d[51:29]} + 24'(inc);
        if (mr[23]) fe++;
        if (fe >= 255) return {d[63], 8'hFF, 23'd0};
        if (fe <= 0)   return {d[63], 31'd0};
        return {d[63], 8'(fe), mr[22:0]};
    endfunction

    function automatic logic [31:0] ref_step(input logic [31:0] a, input logic [31:0] b, input logic m);
        logic an, bn, ai, bi, az, bz;
        logic [31:0] pf;
        real r;
        an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        ai = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        bi = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        az = (a[30:23] == 8'h00);
        bz = (b[30:23] == 8'h00);
        if (an || bn) return QNAN;
        if ((ai && bz) || (az && bi)) return m ? H3 : TWO;
        if (ai || bi) return (a[31] ^ b[31]) ? PINF : NINF;
        if (az || bz) return m ? H3 : TWO;
        pf = r2f(f2r(a) * f2r(b));
        if (pf[30:23] == 8'hFF) return pf[31] ? PINF : NINF;
        if (pf[30:23] == 8'h00) return m ? H3 : TWO;
        r = (m ? 3.0 : 2.0) - f2r(pf);
        if (m) r = r * 0.5;
        return r2f(r);
    endfunction

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual vld/result=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] a, input logic [31:0] b, input logic m,
                        input string req, input logic [31:0] exp);
        @(negedge clk);
        op_a = a; op_b = b; mode = m; in_valid = 1'b1;
        @(negedge clk);
        chk(req, {out_valid, result}, {1'b1, exp});
    endtask

    function automatic logic [31:0] rnd_op(input int lo, input int span);
        return {1'($urandom % 2), 8'(lo + int'($urandom % span)), 23'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed_v;
        logic [31:0] a, b, prev;
        seed_v = int'($urandom(32'd7351));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 in reset", {out_valid, result}, 33'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {out_valid, result}, 33'd0);

        // R3 / R4 directed values
        step(32'h4040_0000, 32'h3E80_0000, 1'b0, "R3 3*0.25", 32'h3FA0_0000);
        step(32'h3F80_0000, 32'h3F80_0000, 1'b1, "R4 1*1", 32'h3F80_0000);
        step(32'hBF80_0000, 32'h3F80_0000, 1'b1, "R4 -1*1", TWO);
        step(32'h3FC0_0000, 32'h3F2A_AAAB, 1'b0, "R3 near recip", ref_step(32'h3FC0_0000, 32'h3F2A_AAAB, 1'b0));

        // R5: infinity times zero, every order and sign, both modes
        for (int mm = 0; mm < 2; mm++) begin
            for (int k = 0; k < 8; k++) begin
                logic [31:0] z, f;
                z = (k & 1) ? NZ : PZ;
                f = (k & 2) ? NINF : PINF;
                if (k & 4) step(f, z, 1'(mm), "R5 inf*0", mm ? H3 : TWO);
                else       step(z, f, 1'(mm), "R5 0*inf", mm ? H3 : TWO);
            end
        end

        // R6: NaN inputs
        step(32'h7FC0_0000, 32'h3F80_0000, 1'b0, "R6 nan a", QNAN);
        step(32'h3F80_0000, 32'hFF80_0001, 1'b1, "R6 snan b", QNAN);
        step(32'h7F80_0001, PZ, 1'b0, "R6 nan*0", QNAN);
        step(PINF, 32'h7FFF_FFFF, 1'b1, "R6 inf*nan", QNAN);

        // R7: infinite products
        step(PINF, TWO, 1'b0, "R7 +inf*2", NINF);
        step(NINF, TWO, 1'b0, "R7 -inf*2", PINF);
        step(TWO, NINF, 1'b1, "R7 2*-inf rsqrt", PINF);
        step(32'h7180_0000, 32'h7180_0000, 1'b0, "R7 overflow", NINF);
        step(32'h7180_0000, 32'hF180_0000, 1'b1, "R7 overflow neg", PINF);

        // R8: flush to zero
        step(32'h0000_0001, 32'h4040_0000, 1'b0, "R8 subnormal a", TWO);
        step(32'h4040_0000, 32'h807F_FFFF, 1'b1, "R8 subnormal b", H3);
        step(32'h0D80_0000, 32'h0D80_0000, 1'b0, "R8 underflow", TWO);
        step(32'h0D80_0000, 32'h8D80_0000, 1'b1, "R8 underflow rsqrt", H3);

        // R9: exact cancellation
        step(32'h3F80_0000, TWO, 1'b0, "R9 1*2", PZ);
        step(32'h3FC0_0000, TWO, 1'b1, "R9 1.5*2", PZ);

        // R2: hold when idle, and valid tracking
        step(32'h4040_0000, 32'h3E80_0000, 1'b0, "R2 setup", 32'h3FA0_0000);
        prev = 32'h3FA0_0000;
        @(negedge clk);
        in_valid = 1'b0; op_a = 32'h3F80_0000; op_b = 32'h3F80_0000; mode = 1'b1;
        @(negedge clk);
        chk("R2 idle hold", {out_valid, result}, {1'b0, prev});
        mode = 1'b0; op_a = PINF; op_b = PZ;
        @(negedge clk);
        chk("R2 idle hold 2", {out_valid, result}, {1'b0, prev});

        // R3 / R4: random operands, general and near-reciprocal pairs
        for (int i = 0; i < 800; i++) begin
            logic m;
            m = 1'(i % 2);
            a = rnd_op(117, 21);
            if ($urandom % 2) b = rnd_op(117, 21);
            else b = {1'($urandom % 2), 8'(254 - int'(a[30:23]) + int'($urandom % 3) - 1), 23'($urandom)};
            step(a, b, m, m ? "R4 random" : "R3 random", ref_step(a, b, m));
        end

        @(negedge clk);
        in_valid = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule